// File: doc/BRIEF.md
# Gated Interrupt Acceptance Arbiter

This block picks, at each instruction boundary, which pending interrupt source a processor core accepts. Four sources can be pending: a system-management request, a non-maskable request (NMI), a hardware maskable request and a virtual interrupt request. A single global enable flag gates all of them. When that flag is set, a fixed priority chooses at most one eligible source per decision. Each source has its own rule for when it is eligible, which depends on the core's interrupt-enable flag, an interrupt-shadow inhibit flag, a management-mode flag, a virtual-masking mode flag and a host interrupt-enable shadow.

Requests arrive as set pulses and are held in pending bits until they are accepted. An accepted decision produces a registered one-hot take strobe and an encoded source selection, and it clears the pending request or requests it consumed. The block also keeps an NMI-in-service flag. Accepting an NMI sets that flag, and a return-from-interrupt pulse clears it. Set and clear command pulses update the global enable flag.

Top module: `irq_accept_arbiter`

## Requirements
- R1: In the first cycle after a synchronous reset, take_o is 0, sel_o is 0, pend_o is 0, gie_o is 1 and nmi_busy_o is 0.
- R2: While gie_o is 0, no source is taken, whatever is pending, and the pending bits stay unchanged.
- R3: Source bit positions are: bit 0 for system-management, bit 1 for NMI, bit 2 for hardware maskable and bit 3 for virtual. Among eligible sources the lowest bit wins. take_o has at most one bit set. On a take, sel_o holds the index of the taken bit.
- R4: A system-management request is eligible only while mgmt_mode_i is 0. Taking it clears pending bit 0 only.
- R5: An NMI is eligible only while nmi_busy_o is 0. Taking it clears pending bit 1 and sets nmi_busy_o in the same cycle that take_o[1] appears.
- R6: A pulse on iret_i clears nmi_busy_o at the next clock, unless an NMI is taken in that same cycle.
- R7: With vmask_mode_i at 1, a hardware maskable request is eligible when host_ie_i is 1. With vmask_mode_i at 0, it is eligible when core_ie_i is 1 and shadow_i is 0.
- R8: Taking a hardware maskable request clears both pending bit 2 and pending bit 3.
- R9: A virtual request is eligible only when core_ie_i is 1 and shadow_i is 0, in either masking mode. Taking it clears pending bit 3 only.
- R10: gie_set_i sets gie_o and gie_clr_i clears it at the next clock. If both pulse in the same cycle, gie_o becomes 0.
- R11: A decision is made only in a cycle with boundary_i at 1. take_o is registered: it appears at the next clock for exactly one cycle. The pending clears land on that same clock.
- R12: A request set pulse that arrives in the same cycle as a take clearing that request leaves the request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set_i | input | 4 | Request set pulses, one bit per source |
| boundary_i | input | 1 | Instruction boundary; a decision is made this cycle |
| gie_set_i | input | 1 | Set-global-enable command pulse |
| gie_clr_i | input | 1 | Clear-global-enable command pulse |
| core_ie_i | input | 1 | Core interrupt-enable flag |
| shadow_i | input | 1 | Interrupt-shadow inhibit flag |
| mgmt_mode_i | input | 1 | Core is in management mode |
| vmask_mode_i | input | 1 | Virtual-masking mode |
| host_ie_i | input | 1 | Host interrupt-enable shadow |
| iret_i | input | 1 | Return-from-interrupt pulse |
| take_o | output | 4 | One-hot take strobe, one cycle |
| sel_o | output | 2 | Index of the last taken source |
| pend_o | output | 4 | Pending request bits |
| gie_o | output | 1 | Global interrupt enable flag |
| nmi_busy_o | output | 1 | NMI-in-service flag |

## Verification
Every result is due one clock after the cycle that causes it. A request pulse shows in pend_o, and can be decided on, one clock after the pulse. take_o, sel_o, the pending clears and the NMI-in-service set all appear one clock after the boundary cycle. gie_o and the iret clear also follow their pulse by one clock. The bench drives inputs on the falling edge and samples on the next falling edge, which lies half a period after the edge where the result is registered. It then checks one further falling edge later that the take strobe has dropped back to zero.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NSRC  = 4;
  localparam int SEL_W = $clog2(NSRC);

  typedef enum logic [SEL_W-1:0] {
    SRC_SMI  = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_HW   = 2'd2,
    SRC_VIRQ = 2'd3
  } src_e;
endpackage

// File: rtl/irq_pend_regs.sv
module irq_pend_regs #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  always_ff @(posedge clk) begin
    if (rst) pend_o <= '0;
    else     pend_o <= (pend_o & ~clr_i) | set_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_keep
    AST_SET_KEPT: assert property (@(posedge clk) disable iff (rst)
      $past(set_i[g]) && !$past(rst) |-> pend_o[g]); // R12
  end
endmodule

// File: rtl/irq_gate_flags.sv
module irq_gate_flags (
  input  logic clk,
  input  logic rst,
  input  logic gie_set_i,
  input  logic gie_clr_i,
  input  logic nmi_take_i,
  input  logic iret_i,
  output logic gie_o,
  output logic nmi_busy_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gie_o      <= 1'b1;
      nmi_busy_o <= 1'b0;
    end else begin
      if (gie_clr_i)      gie_o <= 1'b0;
      else if (gie_set_i) gie_o <= 1'b1;
      if (nmi_take_i)     nmi_busy_o <= 1'b1;
      else if (iret_i)    nmi_busy_o <= 1'b0;
    end
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(gie_clr_i) && !$past(rst) |-> !gie_o); // R10
  AST_IRET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(iret_i) && !$past(nmi_take_i) && !$past(rst) |-> !nmi_busy_o); // R6
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N     = 4,
  parameter int SEL_W = $clog2(N)
) (
  input  logic [N-1:0]     elig_i,
  output logic [N-1:0]     grant_o,
  output logic [SEL_W-1:0] idx_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_accept_arbiter.sv
module irq_accept_arbiter
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  req_set_i,
  input  logic             boundary_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  input  logic             core_ie_i,
  input  logic             shadow_i,
  input  logic             mgmt_mode_i,
  input  logic             vmask_mode_i,
  input  logic             host_ie_i,
  input  logic             iret_i,
  output logic [NSRC-1:0]  take_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [NSRC-1:0]  pend_o,
  output logic             gie_o,
  output logic             nmi_busy_o
);
  logic [NSRC-1:0]  elig, grant, clr;
  logic [SEL_W-1:0] idx;
  logic             open_win;

  irq_pend_regs #(.N(NSRC)) i_pend (
    .clk(clk), .rst(rst), .set_i(req_set_i), .clr_i(clr), .pend_o(pend_o)
  );

  irq_gate_flags i_flags (
    .clk(clk), .rst(rst), .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i),
    .nmi_take_i(grant[SRC_NMI]), .iret_i(iret_i),
    .gie_o(gie_o), .nmi_busy_o(nmi_busy_o)
  );

  always_comb begin
    open_win       = boundary_i & gie_o;
    elig           = '0;
    elig[SRC_SMI]  = pend_o[SRC_SMI] & ~mgmt_mode_i;
    elig[SRC_NMI]  = pend_o[SRC_NMI] & ~nmi_busy_o;
    elig[SRC_HW]   = pend_o[SRC_HW] &
                     (vmask_mode_i ? host_ie_i : (core_ie_i & ~shadow_i));
    elig[SRC_VIRQ] = pend_o[SRC_VIRQ] & core_ie_i & ~shadow_i;
    if (!open_win) elig = '0;
  end

  irq_prio_sel #(.N(NSRC), .SEL_W(SEL_W)) i_sel (
    .elig_i(elig), .grant_o(grant), .idx_o(idx)
  );

  always_comb begin
    clr = grant;
    if (grant[SRC_HW]) clr[SRC_VIRQ] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o <= '0;
      sel_o  <= '0;
    end else begin
      take_o <= grant;
      if (grant != '0) sel_o <= idx;
    end
  end

  AST_TAKE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take_o)); // R3
  AST_NO_TAKE_GIE_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(gie_o) |-> take_o == '0); // R2
  AST_TAKE_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(boundary_i) |-> take_o == '0); // R11
  AST_SMI_NOT_IN_MGMT: assert property (@(posedge clk) disable iff (rst)
    take_o[SRC_SMI] |-> !$past(mgmt_mode_i)); // R4
  AST_NMI_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    take_o[SRC_NMI] |-> nmi_busy_o); // R5
  AST_VIRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    take_o[SRC_VIRQ] |-> $past(core_ie_i) && !$past(shadow_i)); // R9
endmodule

// File: tb/test_irq_accept_arbiter.sv
`timescale 1ns/1ps
module test_irq_accept_arbiter;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] req_set_i;
  logic       boundary_i, gie_set_i, gie_clr_i, core_ie_i, shadow_i;
  logic       mgmt_mode_i, vmask_mode_i, host_ie_i, iret_i;
  logic [3:0] take_o, pend_o;
  logic [1:0] sel_o;
  logic       gie_o, nmi_busy_o;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_accept_arbiter i_irq_accept_arbiter (
    .clk(clk), .rst(rst), .req_set_i(req_set_i), .boundary_i(boundary_i),
    .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .core_ie_i(core_ie_i),
    .shadow_i(shadow_i), .mgmt_mode_i(mgmt_mode_i), .vmask_mode_i(vmask_mode_i),
    .host_ie_i(host_ie_i), .iret_i(iret_i), .take_o(take_o), .sel_o(sel_o),
    .pend_o(pend_o), .gie_o(gie_o), .nmi_busy_o(nmi_busy_o)
  );

  // {req[3:0], mgmt, core_ie, shadow, vmask, host_ie, gie_off, exp_take[3:0], exp_pend[3:0]}
  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {4'b1111, 6'b010000, 4'b0001, 4'b1110},  // R3 SMI first
    {4'b1110, 6'b010000, 4'b0010, 4'b1100},  // R3 NMI next
    {4'b1100, 6'b010000, 4'b0100, 4'b0000},  // R8 HW clears VIRQ
    {4'b1000, 6'b010000, 4'b1000, 4'b0000},  // R9 VIRQ alone
    {4'b1111, 6'b010001, 4'b0000, 4'b1111},  // R2 global off
    {4'b0011, 6'b110000, 4'b0010, 4'b0001},  // R4 SMI blocked in mgmt
    {4'b0100, 6'b000110, 4'b0100, 4'b0000},  // R7 vmask, host ie
    {4'b0100, 6'b010100, 4'b0000, 4'b0100},  // R7 vmask, host ie off
    {4'b0100, 6'b011000, 4'b0000, 4'b0100},  // R7 shadow blocks
    {4'b1100, 6'b000110, 4'b0100, 4'b0000},  // R8 vmask HW clears VIRQ
    {4'b1100, 6'b010100, 4'b1000, 4'b0100},  // R9 only VIRQ cleared
    {4'b1000, 6'b011000, 4'b0000, 4'b1000},  // R9 shadow blocks
    {4'b1000, 6'b000110, 4'b0000, 4'b1000}   // R9 needs core ie
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_set_i = '0; boundary_i = 0; gie_set_i = 0; gie_clr_i = 0; iret_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle(); rst = 1;
    core_ie_i = 0; shadow_i = 0; mgmt_mode_i = 0; vmask_mode_i = 0; host_ie_i = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic pulse_req(input logic [3:0] r);
    req_set_i = r; @(negedge clk); req_set_i = '0;
  endtask

  initial begin : watchdog
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] exp_sel;
    rst = 1; idle();
    core_ie_i = 0; shadow_i = 0; mgmt_mode_i = 0; vmask_mode_i = 0; host_ie_i = 0;
    do_reset();
    chk("R1 take", take_o, 0);
    chk("R1 sel", sel_o, 0);
    chk("R1 pend", pend_o, 0);
    chk("R1 gie", gie_o, 1);
    chk("R1 nmi_busy", nmi_busy_o, 0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      if (VEC[v][8]) begin gie_clr_i = 1; @(negedge clk); gie_clr_i = 0; end
      pulse_req(VEC[v][17:14]);
      mgmt_mode_i = VEC[v][13]; core_ie_i = VEC[v][12]; shadow_i = VEC[v][11];
      vmask_mode_i = VEC[v][10]; host_ie_i = VEC[v][9];
      boundary_i = 1;
      @(negedge clk);
      boundary_i = 0;
      chk($sformatf("vec%0d R3/R7 take", v), take_o, VEC[v][7:4]);
      chk($sformatf("vec%0d R8/R9 pend", v), pend_o, VEC[v][3:0]);
      if (VEC[v][7:4] != 0) begin
        exp_sel = 0;
        for (int b = 0; b < 4; b++) if (VEC[v][4+b]) exp_sel = 2'(b);
        chk($sformatf("vec%0d R3 sel", v), sel_o, exp_sel);
      end
      @(negedge clk);
      chk($sformatf("vec%0d R11 pulse", v), take_o, 0);
    end

    // R5/R6 NMI in service
    do_reset();
    pulse_req(4'b0010);
    boundary_i = 1; @(negedge clk); boundary_i = 0;
    chk("R5 nmi take", take_o, 4'b0010);
    chk("R5 busy set", nmi_busy_o, 1);
    pulse_req(4'b0010);
    boundary_i = 1; @(negedge clk); boundary_i = 0;
    chk("R5 nmi blocked", take_o, 0);
    chk("R5 nmi still pending", pend_o, 4'b0010);
    iret_i = 1; @(negedge clk); iret_i = 0;
    chk("R6 busy cleared", nmi_busy_o, 0);
    boundary_i = 1; @(negedge clk); boundary_i = 0;
    chk("R6 nmi retaken", take_o, 4'b0010);

    // R10 clear wins over set
    do_reset();
    gie_set_i = 1; gie_clr_i = 1; @(negedge clk); gie_set_i = 0; gie_clr_i = 0;
    chk("R10 clear wins", gie_o, 0);
    pulse_req(4'b0001);
    boundary_i = 1; @(negedge clk); boundary_i = 0;
    chk("R2 blocked while off", take_o, 0);
    gie_set_i = 1; @(negedge clk); gie_set_i = 0;
    chk("R10 set", gie_o, 1);
    boundary_i = 1; @(negedge clk); boundary_i = 0;
    chk("R10 take after set", take_o, 4'b0001);

    // R11 no decision without boundary
    do_reset();
    pulse_req(4'b0001);
    repeat (3) @(negedge clk);
    chk("R11 no boundary take", take_o, 0);
    chk("R11 no boundary pend", pend_o, 4'b0001);

    // R12 new pulse in the same cycle as the clear is kept
    do_reset();
    core_ie_i = 1;
    pulse_req(4'b1000);
    boundary_i = 1; req_set_i = 4'b1000;
    @(negedge clk);
    boundary_i = 0; req_set_i = 0;
    chk("R12 virq taken", take_o, 4'b1000);
    chk("R12 virq kept", pend_o, 4'b1000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule